// File: doc/BRIEF.md
# Two-Wire Synthesizer Control Slave

This block is the control port of a PLL frequency synthesizer. It listens to an oversampled two-wire serial bus and drives an open-drain pull-down on the data line. A master uses it to load three things. The first is the 15-bit programmable divider ratio. The second is a 7-bit control word that holds the pump current, test, prescaler, reference-ratio and drive-disable flags. The third is a port register that drives four switching outputs. The master can also read back a status byte. That byte reports power-on, loop lock, the three port input levels and a 3-bit converter code.

After the address, the leading bit of each written byte says what kind of byte it is. A leading 0 starts a divider pair and a leading 1 starts a control/port pair. The partner byte of a pair always follows its first byte. Pairs can keep arriving without a new address until STOP, so a master can step the frequency continuously. The block samples SCL and SDA on the system clock, which must run many times faster than the bus.

Top module: `synth_bus_slave`

## Requirements
- R1: After reset, divWord, ctrlWord and portWord are all 0. P0..P2 reset to 0, which means active, and P6 resets to 0, which means off. The POR flag is 1 and sdaPullLow is 0.
- R2: The 7-bit address 1100000 is always accepted. The address {11000, addrSel} is also accepted. Bit 0 of the address byte is the direction: 0 means write and 1 means read. Any other address gets no acknowledge and changes nothing.
- R3: sdaPullLow is 1 for the whole 9th SCL clock that follows a matched address or any written data byte.
- R4: A data byte with bit 7 = 0 carries divider bits 14..8 in its bits 6..0, and the next byte carries bits 7..0. divWord changes only on the 8th rising SCL edge of that second byte.
- R5: A data byte with bit 7 = 1 loads its bits 6..0 into ctrlWord[6:0] on its own 8th rising SCL edge. From bit 6 down to bit 0 the fields are: pump current, divider test, pump disable, prescaler on, reference select high, reference select low, drive disable.
- R6: The byte that follows a control byte sets portWord = {b6, b2, b1, b0}, which is {P6, P2, P1, P0}. Bits 7, 5, 4 and 3 of that byte are ignored.
- R7: Divider pairs and control/port pairs may follow one another in any order within one write transfer, up to STOP.
- R8: A read returns {POR, lockIn, portIn[0], portIn[1], portIn[2], adcCode[2:0]} MSB first. Each bit is driven after a falling SCL edge.
- R9: If the master acknowledges, the block sends a fresh status byte. If the master does not acknowledge, the block releases SDA.
- R10: pwrFail sets the POR flag. A STOP that ends a read transfer clears it.
- R11: A START or STOP that arrives in the middle of a byte drops that byte and leaves every register unchanged. Each new address restarts the pair sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled bus clock level |
| sdaIn | input | 1 | Sampled bus data level |
| addrSel | input | 2 | Code selecting the second accepted address |
| pwrFail | input | 1 | Supply-drop indication, sets POR |
| lockIn | input | 1 | Loop lock indication |
| portIn | input | 3 | Port input levels, P0 in bit 0 |
| adcCode | input | 3 | Converter result |
| sdaPullLow | output | 1 | Open-drain pull-down enable for SDA |
| divWord | output | 15 | Programmable divider ratio |
| ctrlWord | output | 7 | Control flags |
| portWord | output | 4 | {P6, P2, P1, P0} port outputs |

## Verification
Errors in byte steering show up directly at the outputs. A stale pair-position state makes the byte after a new address land in the wrong register, so divWord or ctrlWord takes a wrong value on the 8th rising edge of that byte. A bit counter that is off by one moves the acknowledge window, and the master sees this as a missing acknowledge in the same byte slot. A status or POR fault appears in the first bit read after the address, or one read transfer later for the POR clear.

// File: rtl/synth_bus_pkg.sv
package synth_bus_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACKA, S_WR, S_ACKW, S_RD, S_ACKR
  } busState_t;

  typedef enum logic [1:0] {
    PAIR_FIRST, PAIR_DIV2, PAIR_CTL2
  } pairPos_t;

  typedef struct packed {
    logic shiftIn;   // capture the bit on a rising SCL edge
    logic takeByte;  // a written data byte is complete
    logic seqReset;  // a new address restarts pairing
    logic loadTx;    // snapshot the status into the transmit shifter
    logic shiftTx;   // advance the transmit shifter
    logic porClr;    // a read transfer ended with STOP
  } dpStrobe_t;
endpackage

// File: rtl/synth_bus_ctrl.sv
module synth_bus_ctrl
  import synth_bus_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      addrHit,
  input  logic      addrRead,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sdaPullLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic sclQ, sdaQ, hitQ, readQ, masterAck, readXfer;

  logic sclRise, sclFall, startSeen, stopSeen;
  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;

  always_comb begin
    strobe = '0;
    strobe.shiftIn  = sclRise & ((state == S_ADDR) | (state == S_WR));
    strobe.takeByte = sclRise & (state == S_WR) & (bitCnt == LAST_BIT);
    strobe.seqReset = startSeen;
    strobe.loadTx   = sclFall & (((state == S_ACKA) & readQ) | ((state == S_ACKR) & masterAck));
    strobe.shiftTx  = sclFall & (state == S_RD) & (bitCnt != FULL_CNT);
    strobe.porClr   = stopSeen & readXfer;
  end

  assign sdaPullLow = (state == S_ACKA) | (state == S_ACKW) | ((state == S_RD) & ~txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      bitCnt <= '0;
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      hitQ <= 1'b0;
      readQ <= 1'b0;
      masterAck <= 1'b0;
      readXfer <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startSeen) begin
        state <= S_ADDR;
        bitCnt <= '0;
      end else if (stopSeen) begin
        state <= S_IDLE;
        readXfer <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) begin
                hitQ <= addrHit;
                readQ <= addrRead;
              end
            end else if (sclFall && bitCnt == FULL_CNT) begin
              state <= hitQ ? S_ACKA : S_IDLE;
            end
          end
          S_ACKA: if (sclFall) begin
            state <= readQ ? S_RD : S_WR;
            bitCnt <= '0;
            readXfer <= readQ;
          end
          S_WR: begin
            if (sclRise) bitCnt <= bitCnt + 1'b1;
            else if (sclFall && bitCnt == FULL_CNT) state <= S_ACKW;
          end
          S_ACKW: if (sclFall) begin
            state <= S_WR;
            bitCnt <= '0;
          end
          S_RD: begin
            if (sclRise) bitCnt <= bitCnt + 1'b1;
            else if (sclFall && bitCnt == FULL_CNT) state <= S_ACKR;
          end
          S_ACKR: begin
            if (sclRise) masterAck <= ~sdaIn;
            else if (sclFall) begin
              state <= masterAck ? S_RD : S_IDLE;
              bitCnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_bus_dp.sv
module synth_bus_dp
  import synth_bus_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 15,
  parameter int CTRL_W = 7,
  parameter int SEL_W  = 2,
  parameter int ADC_W  = 3,
  parameter int PIN_W  = 3,
  parameter logic [6-SEL_W:0] ADDR_HI = '0,
  parameter logic [6:0] ADDR_FIXED = 7'b1100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  input  logic [SEL_W-1:0]  addrSel,
  input  logic              pwrFail,
  input  logic              lockIn,
  input  logic [PIN_W-1:0]  portIn,
  input  logic [ADC_W-1:0]  adcCode,
  input  dpStrobe_t         strobe,
  output logic              addrHit,
  output logic              addrRead,
  output logic              txBit,
  output logic              porFlag,
  output logic [DIV_W-1:0]  divWord,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [PIN_W:0]    portWord
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [BYTE_W-1:0] rxShift, txShift, nextByte, statusByte;
  logic [HI_W-1:0] divHi;
  pairPos_t pairPos;
  logic [PIN_W-1:0] pinsReversed;

  assign nextByte = {rxShift[BYTE_W-2:0], sdaIn};
  assign addrHit  = (nextByte[7:1] == ADDR_FIXED) || (nextByte[7:1] == {ADDR_HI, addrSel});
  assign addrRead = nextByte[0];
  assign txBit    = txShift[BYTE_W-1];

  // status shows P0 in the highest input slot
  for (genvar i = 0; i < PIN_W; i++) begin : g_pins
    assign pinsReversed[PIN_W-1-i] = portIn[i];
  end
  assign statusByte = {porFlag, lockIn, pinsReversed, adcCode};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      divHi <= '0;
      pairPos <= PAIR_FIRST;
      porFlag <= 1'b1;
      divWord <= '0;
      ctrlWord <= '0;
      portWord <= '0;
    end else begin
      if (strobe.shiftIn) rxShift <= nextByte;
      if (strobe.loadTx) txShift <= statusByte;
      else if (strobe.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (pwrFail) porFlag <= 1'b1;
      else if (strobe.porClr) porFlag <= 1'b0;
      if (strobe.seqReset) pairPos <= PAIR_FIRST;
      else if (strobe.takeByte) begin
        unique case (pairPos)
          PAIR_DIV2: begin
            divWord <= {divHi, nextByte};
            pairPos <= PAIR_FIRST;
          end
          PAIR_CTL2: begin
            portWord <= {nextByte[6], nextByte[PIN_W-1:0]};
            pairPos <= PAIR_FIRST;
          end
          default: begin
            if (nextByte[BYTE_W-1]) begin
              ctrlWord <= nextByte[CTRL_W-1:0];
              pairPos <= PAIR_CTL2;
            end else begin
              divHi <= nextByte[HI_W-1:0];
              pairPos <= PAIR_DIV2;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_bus_slave.sv
module synth_bus_slave
  import synth_bus_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int CTRL_W = 7,
  parameter int SEL_W  = 2,
  parameter int ADC_W  = 3,
  parameter int PIN_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [SEL_W-1:0]  addrSel,
  input  logic              pwrFail,
  input  logic              lockIn,
  input  logic [PIN_W-1:0]  portIn,
  input  logic [ADC_W-1:0]  adcCode,
  output logic              sdaPullLow,
  output logic [DIV_W-1:0]  divWord,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [PIN_W:0]    portWord
);
  localparam int BYTE_W = 8;
  localparam logic [6-SEL_W:0] ADDR_HI = {3'b110, {(4 - SEL_W){1'b0}}};

  dpStrobe_t strobe;
  logic addrHit, addrRead, txBit, porFlag;

  synth_bus_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .addrRead(addrRead), .txBit(txBit),
    .strobe(strobe), .sdaPullLow(sdaPullLow)
  );

  synth_bus_dp #(
    .BYTE_W(BYTE_W), .DIV_W(DIV_W), .CTRL_W(CTRL_W), .SEL_W(SEL_W),
    .ADC_W(ADC_W), .PIN_W(PIN_W), .ADDR_HI(ADDR_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .addrSel(addrSel),
    .pwrFail(pwrFail), .lockIn(lockIn), .portIn(portIn), .adcCode(adcCode),
    .strobe(strobe), .addrHit(addrHit), .addrRead(addrRead), .txBit(txBit),
    .porFlag(porFlag), .divWord(divWord), .ctrlWord(ctrlWord), .portWord(portWord)
  );
endmodule

// File: rtl/synth_bus_chk.sv
module synth_bus_chk #(
  parameter int DIV_W  = 15,
  parameter int CTRL_W = 7,
  parameter int PIN_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input logic              pwrFail,
  input logic              porFlag,
  input logic [DIV_W-1:0]  divWord,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [PIN_W:0]    portWord
);
  // R3 / R8: the slave starts pulling SDA low only after SCL was low
  p_pull_on_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !$past(sclIn));

  // R4: the divider register moves only right after a rising SCL edge
  p_div_on_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divWord) |-> ($past(sclIn) && !$past(sclIn, 2)));

  // R5: the control register moves only right after a rising SCL edge
  p_ctrl_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlWord) |-> ($past(sclIn) && !$past(sclIn, 2)));

  // R6: the port register moves only right after a rising SCL edge
  p_port_on_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portWord) |-> ($past(sclIn) && !$past(sclIn, 2)));

  // R10: a supply drop always raises the POR flag
  p_por_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> porFlag);
endmodule

bind synth_bus_slave synth_bus_chk #(.DIV_W(DIV_W), .CTRL_W(CTRL_W), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .pwrFail(pwrFail), .porFlag(porFlag), .divWord(divWord),
  .ctrlWord(ctrlWord), .portWord(portWord)
);

// File: tb/sim_synth_bus_slave.sv
module sim_synth_bus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] addrSel = 2'd0;
  logic pwrFail = 1'b0, lockIn = 1'b0;
  logic [2:0] portIn = 3'd0, adcCode = 3'd0;
  logic sdaPullLow;
  logic [14:0] divWord;
  logic [6:0] ctrlWord;
  logic [3:0] portWord;
  logic sdaLine;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  assign sdaLine = sdaM & ~sdaPullLow;
  always #(CLK_PERIOD/2) clk = ~clk;

  synth_bus_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .pwrFail(pwrFail), .lockIn(lockIn), .portIn(portIn), .adcCode(adcCode),
    .sdaPullLow(sdaPullLow), .divWord(divWord), .ctrlWord(ctrlWord), .portWord(portWord)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b1; waitQ(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ(Q);
      sclM = 1'b1; waitQ(Q);
      sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q/2);
    acked = ~sdaLine;
    waitQ(Q/2);
    sclM = 1'b0;
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(Q);
      sclM = 1'b1; waitQ(Q/2);
      b[i] = sdaLine;
      waitQ(Q/2);
      sclM = 1'b0;
    end
    waitQ(1);
    sdaM = giveAck ? 1'b0 : 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sclM = 1'b0; waitQ(1);
    sdaM = 1'b1;
  endtask

  task automatic testReset();
    check(divWord == 0, "R1 divWord", divWord, 0);
    check(ctrlWord == 0, "R1 ctrlWord", ctrlWord, 0);
    check(portWord == 0, "R1 portWord", portWord, 0);
    check(sdaPullLow == 0, "R1 sdaPullLow", sdaPullLow, 0);
  endtask

  task automatic testDivider();
    bit a;
    startCond();
    sendByte(8'hC0, a); check(a, "R3 address ack", a, 1);
    sendByte(8'h12, a); check(a, "R3 data ack", a, 1);
    check(divWord == 0, "R4 no update after first byte", divWord, 0);
    sendByte(8'h34, a);
    check(divWord == 15'h1234, "R4 divider value", divWord, 15'h1234);
    stopCond();
  endtask

  task automatic testControlStream();
    bit a;
    startCond();
    sendByte(8'hC0, a);
    sendByte(8'hD5, a);
    check(ctrlWord == 7'h55, "R5 control value", ctrlWord, 7'h55);
    sendByte(8'h45, a);
    check(portWord == 4'hD, "R6 port value", portWord, 4'hD);
    sendByte(8'hB8, a);
    sendByte(8'h3A, a);
    check(portWord == 4'h2, "R6 ignored bits", portWord, 4'h2);
    sendByte(8'h05, a);
    sendByte(8'h67, a);
    check(divWord == 15'h0567, "R7 divider after control pair", divWord, 15'h0567);
    check(ctrlWord == 7'h38, "R7 second control byte", ctrlWord, 7'h38);
    stopCond();
  endtask

  task automatic testAddressSelect();
    bit a;
    addrSel = 2'd2;
    startCond();
    sendByte(8'hC4, a); check(a, "R2 selected address acked", a, 1);
    stopCond();
    startCond();
    sendByte(8'hC6, a); check(!a, "R2 other address not acked", a, 0);
    sendByte(8'h01, a);
    sendByte(8'h02, a);
    stopCond();
    check(divWord == 15'h0567, "R2 foreign address no effect", divWord, 15'h0567);
    addrSel = 2'd0;
  endtask

  task automatic testRead();
    bit a;
    logic [7:0] b;
    lockIn = 1'b1; portIn = 3'b001; adcCode = 3'b101;
    startCond();
    sendByte(8'hC1, a); check(a, "R2 read address acked", a, 1);
    readByte(1'b1, b); check(b == 8'hE5, "R8 status byte", b, 8'hE5);
    readByte(1'b0, b); check(b == 8'hE5, "R9 repeated status", b, 8'hE5);
    waitQ(2);
    check(sdaPullLow == 0, "R9 release after nack", sdaPullLow, 0);
    stopCond();
    portIn = 3'b100; adcCode = 3'b010;
    startCond();
    sendByte(8'hC1, a);
    readByte(1'b0, b); check(b == 8'h4A, "R10 POR cleared by stop", b, 8'h4A);
    stopCond();
    @(negedge clk) pwrFail = 1'b1;
    @(negedge clk) pwrFail = 1'b0;
    startCond();
    sendByte(8'hC1, a);
    readByte(1'b0, b); check(b == 8'hCA, "R10 POR set by pwrFail", b, 8'hCA);
    stopCond();
  endtask

  task automatic testAbort();
    bit a;
    startCond();
    sendByte(8'hC0, a);
    sendByte(8'h03, a);
    sendBits(8'h00, 4);
    stopCond();
    check(divWord == 15'h0567, "R11 abort keeps divider", divWord, 15'h0567);
    startCond();
    sendByte(8'hC0, a);
    sendByte(8'h0A, a);
    startCond();
    sendByte(8'hC0, a);
    sendByte(8'h85, a);
    check(ctrlWord == 7'h05, "R11 pairing restarts", ctrlWord, 7'h05);
    check(divWord == 15'h0567, "R11 divider untouched", divWord, 15'h0567);
    stopCond();
  endtask

  initial begin
    waitQ(3);
    rstN = 1'b1;
    waitQ(2);
    testReset();
    testDivider();
    testControlStream();
    testAddressSelect();
    testRead();
    testAbort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule